// File: doc/BRIEF.md
# System Clock Source Select and Divider

This block generates the clock enables for a system and its peripheral groups. It works entirely inside one master clock domain. Three candidate clock sources reach it as single-cycle enable strobes: an internal RC oscillator, a crystal oscillator and a PLL. A 2-bit select code chooses one of these strobes. A 3-bit code sets a power-of-two system divider, which thins the chosen strobe into the system clock enable.

Four peripheral groups each have a second-stage divider. Group 0 serves the serial and I2C units, group 1 the CAN and SPI units, group 2 the ADC and its conversion trigger unit, and group 3 the timer system. Each group divider counts system enable pulses and, under its own 2-bit code, emits that group's clock enable.

A single write strobe loads all codes into pending registers. A pending code moves into use only when the counter it governs completes its current period, so no output period is ever cut short. Boot logic can choose the source select value used at reset through a dedicated input.

Top module: `sclk_divctl`

## Requirements
- R1: Select code 00 makes `stb_rc` the source of `sys_ce`, 01 makes `stb_xo` the source and 10 makes `stb_pll` the source. With system divide code 000, every strobe of the selected source yields one `sys_ce` pulse in the same cycle, and strobes from the other sources yield none.
- R2: Select code 11 behaves exactly like code 00: `stb_rc` is the source.
- R3: System divide codes 000, 001, 010, 011 and 100 produce one `sys_ce` pulse per 1, 2, 4, 8 and 16 selected strobes respectively.
- R4: System divide codes 101, 110 and 111 behave as divide by 1.
- R5: Group g's code is held in `cfg_grp_div[2g+1:2g]`. Codes 00, 01, 10 and 11 produce one `grp_ce[g]` pulse per 1, 2, 4 and 8 `sys_ce` pulses. `grp_ce[g]` is only ever high in a cycle where `sys_ce` is high.
- R6: The four group dividers are independent: each group's rate depends only on its own code field.
- R7: On leaving reset, the select code equals the value of `boot_src_sel` that was present during reset. All divide codes start at zero, so every output runs at divide by 1.
- R8: A code written while a divider is partway through a period takes effect only once that period completes at the old ratio. The first `sys_ce` after the write therefore comes exactly as many strobes after the previous one as the old code demands.
- R9: While `rst_n` is low, `sys_ce` and all bits of `grp_ce` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| boot_src_sel | input | 2 | Source select value loaded during reset |
| stb_rc | input | 1 | Internal RC oscillator enable strobe |
| stb_xo | input | 1 | Crystal oscillator enable strobe |
| stb_pll | input | 1 | PLL enable strobe |
| cfg_wr | input | 1 | Loads all code fields into the pending registers |
| cfg_src_sel | input | 2 | Source select code |
| cfg_sys_div | input | 3 | System divide code |
| cfg_grp_div | input | 8 | Four 2-bit group divide codes, group 0 in the low bits |
| sys_ce | output | 1 | System clock enable |
| grp_ce | output | 4 | Peripheral group clock enables |

## Verification
The three sources are driven with distinct rates: the RC strobe every second cycle, the crystal strobe every third cycle and the PLL strobe every cycle. The number of `sys_ce` pulses in a fixed window therefore shows which source is in use. Each divide code is counted over a window that is a whole multiple of every period, so an off-by-one ratio or a wrong reserved-code fallback changes the count exactly. Group codes are applied in two different permutations, which catches crossed fields or shared counters. A write placed right after a system pulse measures whether the running period still finishes at the old ratio.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int SEL_W   = 2;
  localparam int SDIV_W  = 3;
  localparam int GDIV_W  = 2;
  localparam int SCNT_W  = 4;   // covers divide by 16
  localparam int GCNT_W  = 3;   // covers divide by 8
  localparam int NUM_SRC = 3;

  localparam logic [SEL_W-1:0] SEL_RC  = 2'b00;
  localparam logic [SEL_W-1:0] SEL_XO  = 2'b01;
  localparam logic [SEL_W-1:0] SEL_PLL = 2'b10;
  localparam logic [SEL_W-1:0] SEL_RSV = 2'b11;

  // last count value of one system period; reserved codes fall back to /1
  function automatic logic [SCNT_W-1:0] sys_term(input logic [SDIV_W-1:0] code);
    case (code)
      3'd1:    sys_term = 4'd1;
      3'd2:    sys_term = 4'd3;
      3'd3:    sys_term = 4'd7;
      3'd4:    sys_term = 4'd15;
      default: sys_term = 4'd0;
    endcase
  endfunction

  function automatic logic [GCNT_W-1:0] grp_term(input logic [GDIV_W-1:0] code);
    case (code)
      2'd1:    grp_term = 3'd1;
      2'd2:    grp_term = 3'd3;
      2'd3:    grp_term = 3'd7;
      default: grp_term = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/sclk_rst_sync.sv
module sclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sclk_sys_stage.sv
module sclk_sys_stage
  import sclk_pkg::*;
(
  input  logic                clk,
  input  logic                srst_n,
  input  logic [SEL_W-1:0]    boot_sel,
  input  logic [NUM_SRC-1:0]  src_stb,
  input  logic                wr,
  input  logic [SEL_W-1:0]    new_sel,
  input  logic [SDIV_W-1:0]   new_div,
  output logic                sys_ce
);
  logic [SEL_W-1:0]  pend_sel_q, pend_sel_d, act_sel_q, act_sel_d;
  logic [SDIV_W-1:0] pend_div_q, pend_div_d, act_div_q, act_div_d;
  logic [SCNT_W-1:0] cnt_q, cnt_d, term;
  logic              sel_stb, wrap;

  // source mux, reserved code routes to the RC strobe
  always_comb begin
    case (act_sel_q)
      SEL_XO:  sel_stb = src_stb[1];
      SEL_PLL: sel_stb = src_stb[2];
      default: sel_stb = src_stb[0];
    endcase
  end

  always_comb begin
    term       = sys_term(act_div_q);
    wrap       = srst_n && sel_stb && (cnt_q == term);
    cnt_d      = cnt_q;
    if (sel_stb) cnt_d = (cnt_q == term) ? '0 : cnt_q + 1'b1;
    pend_sel_d = wr   ? new_sel    : pend_sel_q;
    pend_div_d = wr   ? new_div    : pend_div_q;
    act_sel_d  = wrap ? pend_sel_q : act_sel_q;
    act_div_d  = wrap ? pend_div_q : act_div_q;
  end

  assign sys_ce = wrap;

  // select registers load the boot value on every clock while in reset
  always_ff @(posedge clk) begin
    if (!srst_n) begin
      pend_sel_q <= boot_sel;
      act_sel_q  <= boot_sel;
    end else begin
      pend_sel_q <= pend_sel_d;
      act_sel_q  <= act_sel_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_div_q <= '0;
      act_div_q  <= '0;
      cnt_q      <= '0;
    end else begin
      pend_div_q <= pend_div_d;
      act_div_q  <= act_div_d;
      cnt_q      <= cnt_d;
    end
  end

  p_ce_from_source_r1: assert property (@(posedge clk) disable iff (!srst_n)
    sys_ce |-> (|src_stb));
  p_rsv_sel_is_rc_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (act_sel_q == SEL_RSV && sys_ce) |-> src_stb[0]);
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q <= sys_term(act_div_q));
  p_rsv_div_every_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (act_div_q > 3'd4 && sel_stb) |-> sys_ce);
  p_code_held_r8: assert property (@(posedge clk) disable iff (!srst_n)
    !wrap |=> ($stable(act_div_q) && $stable(act_sel_q)));
endmodule

// File: rtl/sclk_grp_div.sv
module sclk_grp_div
  import sclk_pkg::*;
(
  input  logic              clk,
  input  logic              srst_n,
  input  logic              sys_ce,
  input  logic              wr,
  input  logic [GDIV_W-1:0] new_code,
  output logic              grp_ce
);
  logic [GDIV_W-1:0] pend_q, pend_d, act_q, act_d;
  logic [GCNT_W-1:0] cnt_q, cnt_d, term;
  logic              wrap;

  always_comb begin
    term   = grp_term(act_q);
    wrap   = sys_ce && (cnt_q == term);
    cnt_d  = cnt_q;
    if (sys_ce) cnt_d = (cnt_q == term) ? '0 : cnt_q + 1'b1;
    pend_d = wr   ? new_code : pend_q;
    act_d  = wrap ? pend_q   : act_q;
  end

  assign grp_ce = wrap;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
    end
  end

  p_grp_on_sys_r5: assert property (@(posedge clk) disable iff (!srst_n)
    grp_ce |-> sys_ce);
  p_gcnt_in_range_r5: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q <= grp_term(act_q));
  p_gcode_held_r8: assert property (@(posedge clk) disable iff (!srst_n)
    !wrap |=> $stable(act_q));
endmodule

// File: rtl/sclk_divctl.sv
module sclk_divctl
  import sclk_pkg::*;
#(
  parameter int NUM_GRP   = 4,
  parameter int RST_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 boot_src_sel,
  input  logic                       stb_rc,
  input  logic                       stb_xo,
  input  logic                       stb_pll,
  input  logic                       cfg_wr,
  input  logic [1:0]                 cfg_src_sel,
  input  logic [2:0]                 cfg_sys_div,
  input  logic [NUM_GRP*GDIV_W-1:0]  cfg_grp_div,
  output logic                       sys_ce,
  output logic [NUM_GRP-1:0]         grp_ce
);
  logic srst_n;

  sclk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sclk_sys_stage u_sys (
    .clk      (clk),
    .srst_n   (srst_n),
    .boot_sel (boot_src_sel),
    .src_stb  ({stb_pll, stb_xo, stb_rc}),
    .wr       (cfg_wr),
    .new_sel  (cfg_src_sel),
    .new_div  (cfg_sys_div),
    .sys_ce   (sys_ce)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    sclk_grp_div u_grp (
      .clk      (clk),
      .srst_n   (srst_n),
      .sys_ce   (sys_ce),
      .wr       (cfg_wr),
      .new_code (cfg_grp_div[g*GDIV_W +: GDIV_W]),
      .grp_ce   (grp_ce[g])
    );
  end

  p_quiet_in_reset_r9: assert property (@(posedge clk)
    !rst_n |-> (!sys_ce && grp_ce == '0));
endmodule

// File: tb/sclk_divctl_tb_top.sv
module sclk_divctl_tb_top;
  localparam int WIN = 768;   // multiple of every source period times every ratio

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] boot_src_sel;
  logic       stb_rc, stb_xo, stb_pll;
  logic       cfg_wr;
  logic [1:0] cfg_src_sel;
  logic [2:0] cfg_sys_div;
  logic [7:0] cfg_grp_div;
  logic       sys_ce;
  logic [3:0] grp_ce;

  int n_chk = 0, n_bad = 0;
  int sc, bad_align;
  int gc [4];
  int cyc = 0;

  sclk_divctl dut_i (
    .clk(clk), .rst_n(rst_n), .boot_src_sel(boot_src_sel),
    .stb_rc(stb_rc), .stb_xo(stb_xo), .stb_pll(stb_pll),
    .cfg_wr(cfg_wr), .cfg_src_sel(cfg_src_sel), .cfg_sys_div(cfg_sys_div),
    .cfg_grp_div(cfg_grp_div), .sys_ce(sys_ce), .grp_ce(grp_ce)
  );

  always #10 clk = ~clk;

  // source strobes: RC every 2nd cycle, crystal every 3rd, PLL every cycle
  initial begin
    stb_rc = 1'b0; stb_xo = 1'b0; stb_pll = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      stb_rc  = (cyc % 2 == 0);
      stb_xo  = (cyc % 3 == 0);
      stb_pll = 1'b1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] sel, input logic [2:0] sd, input logic [7:0] gd);
    @(negedge clk);
    cfg_src_sel = sel; cfg_sys_div = sd; cfg_grp_div = gd; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic measure();
    sc = 0; bad_align = 0;
    for (int g = 0; g < 4; g++) gc[g] = 0;
    repeat (WIN) begin
      @(negedge clk);
      if (sys_ce) sc++;
      for (int g = 0; g < 4; g++)
        if (grp_ce[g]) begin
          gc[g]++;
          if (!sys_ce) bad_align++;
        end
    end
  endtask

  task automatic settle();
    repeat (400) @(negedge clk);
  endtask

  task automatic t_reset();
    boot_src_sel = 2'b01;
    rst_n = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk("R9", "sys_ce in reset", int'(sys_ce), 0);
      chk("R9", "grp_ce in reset", int'(grp_ce), 0);
    end
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    measure();
    chk("R7", "boot select crystal sys count", sc, WIN / 3);
    for (int g = 0; g < 4; g++) chk("R7", "group at reset divide", gc[g], WIN / 3);
  endtask

  task automatic t_select();
    write_cfg(2'b00, 3'd0, 8'h00); settle(); measure();
    chk("R1", "select RC", sc, WIN / 2);
    write_cfg(2'b01, 3'd0, 8'h00); settle(); measure();
    chk("R1", "select crystal", sc, WIN / 3);
    write_cfg(2'b10, 3'd0, 8'h00); settle(); measure();
    chk("R1", "select PLL", sc, WIN);
    write_cfg(2'b11, 3'd0, 8'h00); settle(); measure();
    chk("R2", "reserved select as RC", sc, WIN / 2);
  endtask

  task automatic t_sysdiv();
    for (int k = 0; k < 8; k++) begin
      write_cfg(2'b10, 3'(k), 8'h00); settle(); measure();
      if (k <= 4) chk("R3", $sformatf("system divide code %0d", k), sc, WIN >> k);
      else        chk("R4", $sformatf("reserved divide code %0d", k), sc, WIN);
    end
  endtask

  task automatic t_groups();
    // crystal /2 gives WIN/6 system pulses
    write_cfg(2'b01, 3'd1, 8'b00_01_10_11); settle(); measure();
    chk("R5", "system rate under groups", sc, WIN / 6);
    chk("R5", "group pulse without system pulse", bad_align, 0);
    for (int g = 0; g < 4; g++)
      chk("R5", $sformatf("group %0d code %0d", g, 3 - g), gc[g], (WIN / 6) >> (3 - g));
    write_cfg(2'b01, 3'd1, 8'b11_10_01_00); settle(); measure();
    for (int g = 0; g < 4; g++)
      chk("R6", $sformatf("group %0d code %0d permuted", g, g), gc[g], (WIN / 6) >> g);
  endtask

  task automatic t_wrap();
    int gap;
    write_cfg(2'b10, 3'd4, 8'h00); settle();
    do @(negedge clk); while (!sys_ce);
    cfg_src_sel = 2'b10; cfg_sys_div = 3'd0; cfg_grp_div = 8'h00; cfg_wr = 1'b1;
    gap = 0;
    do begin
      @(negedge clk);
      cfg_wr = 1'b0;
      gap++;
    end while (!sys_ce && gap < 64);
    chk("R8", "old period completes before new code", gap, 16);
    @(negedge clk);
    chk("R8", "new code in use after wrap", int'(sys_ce), 1);
  endtask

  initial begin
    cfg_wr = 1'b0; cfg_src_sel = 2'b00; cfg_sys_div = 3'd0; cfg_grp_div = 8'h00;
    boot_src_sel = 2'b01; rst_n = 1'b0;
    t_reset();
    t_select();
    t_sysdiv();
    t_groups();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule